// File: doc/BRIEF.md
# Display Link Lane and Rate Selector

This block chooses how many lanes and which link rate a serial display link should run at for a given video mode. It takes the requested pixel clock in kHz, the colour depth per component, what the sink can do (its most lanes, its top link rate, and whether it accepts the highest rate), and a flag that marks a bridge device that needs a fixed rate. It then works out the cheapest configuration whose payload capacity covers the pixel stream.

The capacity of each candidate is the link rate times the lane count times eight, divided by the bits per pixel and rounded down. One shared restoring divider works this out one quotient bit per clock. The lane count is settled first, at the sink's top rate, with fewer lanes preferred. The rate is then searched from low to high at that lane count. A `start` pulse launches a search, `busy` stays high while it runs, and a one-cycle `done` pulse marks a fresh result. The result stays on the outputs until the next search finishes.

Top module: `link_cfg_picker`

## Requirements
- R1: A `start` pulse seen while `busy` is low samples every input. `busy` then stays high until the result is written. `done` is high for exactly one cycle as `busy` falls. A `start` pulse while `busy` is high is ignored, and the result reflects the first request.
- R2: Bits per pixel are 24 when `comp_bits` is 0, and 3 × `comp_bits` otherwise.
- R3: The lane count tries 1, then 2, then 4. At each step the capacity is floor(`sink_rate_khz` × lanes × 8 / bpp). The search stops at the first count whose capacity is at least `pix_khz`. It also stops as soon as the count is no longer below `sink_lanes` (legal values 1, 2, 4), and that count is the result.
- R4: With the chosen lane count, the rates 162000, 270000 and 540000 kHz are tried in that order. The first whose capacity covers `pix_khz` is selected. The 540000 candidate is only tried when `fast_ok` is 1.
- R5: If no tried rate covers `pix_khz`, the selected rate is `sink_rate_khz`.
- R6: When `fixed_bridge` is 1, the selected rate is 270000 without evaluation. The lane count is still chosen as in R3.
- R7: `mode_bad` is 1 exactly when the selected rate is 540000 and the sampled `fast_ok` is 0.
- R8: Capacity uses integer division rounded down. A pixel clock equal to the rounded capacity fits, and one kHz above it does not.
- R9: After reset, `busy`, `done` and `mode_bad` are 0 and `lanes_out` and `rate_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a search |
| pix_khz | input | PIX_W | Requested pixel clock in kHz |
| comp_bits | input | BPC_W | Bits per colour component, 0 means unknown |
| sink_lanes | input | LANE_W | Most lanes the sink supports (1, 2 or 4) |
| sink_rate_khz | input | RATE_W | Top link rate of the sink in kHz |
| fast_ok | input | 1 | Sink accepts the 540000 kHz rate |
| fixed_bridge | input | 1 | Bridge device that needs the fixed 270000 kHz rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a result is written |
| lanes_out | output | LANE_W | Selected lane count |
| rate_out | output | RATE_W | Selected link rate in kHz |
| mode_bad | output | 1 | Mode rejected: clock too high for the sink |

## Verification
The bench aims at the exact rounding edge of the capacity. It uses depths where the division leaves a remainder and where it does not. A design that rounds up, or tests with strict inequality, picks the next rate one kHz too early or too late. It drives a depth of zero, where a design that takes the product literally would divide by zero and pick the wrong rate. It runs sinks whose top rate is 540000 with the capability flag clear. There a design that tries 540000 anyway returns a clean mode, while the correct one falls back to the sink maximum and flags the mode. It also runs bridge cases and a second start issued mid-search. A wrong design there either evaluates rates it should skip, or lets the late request corrupt the first result.

// File: rtl/link_cfg_picker.sv
module link_cfg_picker #(
  parameter int PIX_W    = 20,
  parameter int RATE_W   = 20,
  parameter int BPC_W    = 4,
  parameter int LANE_W   = 3,
  parameter int RATE_LO  = 162000,
  parameter int RATE_MID = 270000,
  parameter int RATE_HI  = 540000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PIX_W-1:0]  pix_khz,
  input  logic [BPC_W-1:0]  comp_bits,
  input  logic [LANE_W-1:0] sink_lanes,
  input  logic [RATE_W-1:0] sink_rate_khz,
  input  logic              fast_ok,
  input  logic              fixed_bridge,
  output logic              busy,
  output logic              done,
  output logic [LANE_W-1:0] lanes_out,
  output logic [RATE_W-1:0] rate_out,
  output logic              mode_bad
);

  localparam int BPP_W = BPC_W + 2;
  localparam int NUM_W = RATE_W + LANE_W + 3;
  localparam int CNT_W = $clog2(NUM_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_LANE, ST_LDIV, ST_RATE, ST_RDIV} st_t;
  st_t st;

  logic [PIX_W-1:0]  pix_q;
  logic [BPP_W-1:0]  bpp_q;
  logic [LANE_W-1:0] maxl_q, lanes_q;
  logic [RATE_W-1:0] srate_q;
  logic              fast_q, bridge_q;
  logic [1:0]        ridx;

  logic [NUM_W-1:0]  dnum;
  logic [BPP_W-1:0]  drem;
  logic [CNT_W-1:0]  dcnt;
  logic [BPP_W:0]    trial;

  logic [RATE_W-1:0] cand;
  logic              cand_ok, kick, fits, lane_stop;
  logic [NUM_W-1:0]  kick_num;

  assign busy      = (st != ST_IDLE);
  assign cand      = (ridx == 2'd0) ? RATE_W'(RATE_LO) :
                     (ridx == 2'd1) ? RATE_W'(RATE_MID) : RATE_W'(RATE_HI);
  assign cand_ok   = (ridx < 2'd2) || (ridx == 2'd2 && fast_q);
  assign lane_stop = (lanes_q >= maxl_q);
  assign kick      = (st == ST_LANE && !lane_stop) ||
                     (st == ST_RATE && !bridge_q && cand_ok);
  assign kick_num  = (NUM_W'((st == ST_LANE) ? srate_q : cand) * NUM_W'(lanes_q)) << 3;
  assign fits      = ({{(NUM_W-PIX_W){1'b0}}, pix_q} <= dnum);
  assign trial     = {drem, dnum[NUM_W-1]};
  assign mode_bad  = (rate_out == RATE_W'(RATE_HI)) && !fast_q;

  // restoring divider, one quotient bit per cycle; quotient ends in dnum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dnum <= '0;
      drem <= '0;
      dcnt <= '0;
    end else if (kick) begin
      dnum <= kick_num;
      drem <= '0;
      dcnt <= CNT_W'(NUM_W);
    end else if (dcnt != '0) begin
      if (trial >= {1'b0, bpp_q}) begin
        drem <= BPP_W'(trial - {1'b0, bpp_q});
        dnum <= {dnum[NUM_W-2:0], 1'b1};
      end else begin
        drem <= trial[BPP_W-1:0];
        dnum <= {dnum[NUM_W-2:0], 1'b0};
      end
      dcnt <= dcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      pix_q     <= '0;
      bpp_q     <= '0;
      maxl_q    <= '0;
      lanes_q   <= '0;
      srate_q   <= '0;
      fast_q    <= 1'b0;
      bridge_q  <= 1'b0;
      ridx      <= '0;
      lanes_out <= '0;
      rate_out  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          pix_q    <= pix_khz;
          bpp_q    <= (comp_bits == '0) ? BPP_W'(24) : BPP_W'(comp_bits) * BPP_W'(3);
          maxl_q   <= sink_lanes;
          srate_q  <= sink_rate_khz;
          fast_q   <= fast_ok;
          bridge_q <= fixed_bridge;
          lanes_q  <= LANE_W'(1);
          ridx     <= '0;
          st       <= ST_LANE;
        end
        ST_LANE: st <= lane_stop ? ST_RATE : ST_LDIV;
        ST_LDIV: if (dcnt == '0) begin
          if (fits) st <= ST_RATE;
          else begin
            lanes_q <= lanes_q << 1;
            st      <= ST_LANE;
          end
        end
        ST_RATE: begin
          if (bridge_q || !cand_ok) begin
            lanes_out <= lanes_q;
            rate_out  <= bridge_q ? RATE_W'(RATE_MID) : srate_q;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end else st <= ST_RDIV;
        end
        ST_RDIV: if (dcnt == '0) begin
          if (fits) begin
            lanes_out <= lanes_q;
            rate_out  <= cand;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            ridx <= ridx + 1'b1;
            st   <= ST_RATE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_DONE_ENDS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy)); // R1
  AST_LANES_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(lanes_out) == 1); // R3
  AST_BRIDGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    done && bridge_q |-> rate_out == RATE_W'(RATE_MID)); // R6
  AST_HI_ONLY_IF_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fast_q && rate_out == RATE_W'(RATE_HI) |-> srate_q == RATE_W'(RATE_HI)); // R5
  AST_DIV_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> dcnt == '0); // R1

endmodule

// File: tb/test_link_cfg_picker.sv
module test_link_cfg_picker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pix_khz = '0;
  logic [3:0]  comp_bits = '0;
  logic [2:0]  sink_lanes = '0;
  logic [19:0] sink_rate_khz = '0;
  logic        fast_ok = 1'b0;
  logic        fixed_bridge = 1'b0;
  logic        busy, done, mode_bad;
  logic [2:0]  lanes_out;
  logic [19:0] rate_out;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  link_cfg_picker i_link_cfg_picker (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz),
    .comp_bits(comp_bits), .sink_lanes(sink_lanes), .sink_rate_khz(sink_rate_khz),
    .fast_ok(fast_ok), .fixed_bridge(fixed_bridge), .busy(busy), .done(done),
    .lanes_out(lanes_out), .rate_out(rate_out), .mode_bad(mode_bad));

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_cfg(input int pix, input int bpc, input int maxl,
                                     input int srate, input bit fast, input bit bridge,
                                     output int el, output int er);
    longint bpp = (bpc == 0) ? 24 : 3 * bpc;
    el = 1;
    while (el < maxl) begin
      if (pix <= (longint'(srate) * el * 8) / bpp) break;
      el = el * 2;
    end
    if (bridge) er = 270000;
    else if (pix <= (longint'(162000) * el * 8) / bpp) er = 162000;
    else if (pix <= (longint'(270000) * el * 8) / bpp) er = 270000;
    else if (fast && pix <= (longint'(540000) * el * 8) / bpp) er = 540000;
    else er = srate;
  endfunction

  task automatic launch(input int pix, input int bpc, input int maxl, input int srate,
                        input bit fast, input bit bridge);
    @(negedge clk);
    pix_khz = 20'(pix); comp_bits = 4'(bpc); sink_lanes = 3'(maxl);
    sink_rate_khz = 20'(srate); fast_ok = fast; fixed_bridge = bridge;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, done, 1);
  endtask

  task automatic run_case(input string req, input int pix, input int bpc, input int maxl,
                          input int srate, input bit fast, input bit bridge);
    int el, er;
    expect_cfg(pix, bpc, maxl, srate, fast, bridge, el, er);
    launch(pix, bpc, maxl, srate, fast, bridge);
    wait_done(req);
    check({req, " lanes"}, lanes_out, el);
    check({req, " rate"}, rate_out, er);
    check("R7 mode_bad", mode_bad, (er == 540000 && !fast) ? 1 : 0);
  endtask

  task automatic t_reset();
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 lanes", lanes_out, 0);
    check("R9 rate", rate_out, 0);
    check("R9 mode_bad", mode_bad, 0);
  endtask

  task automatic t_depth();
    run_case("R2 depth0", 54000, 0, 4, 270000, 0, 0);
    check("R2 depth0 rate", rate_out, 162000);
    run_case("R2 depth10", 54000, 10, 4, 270000, 0, 0);
    check("R2 depth10 rate", rate_out, 270000);
    run_case("R2 depth6", 72000, 6, 1, 162000, 0, 0);
    check("R2 depth6 rate", rate_out, 162000);
  endtask

  task automatic t_lanes();
    run_case("R3 two", 100000, 8, 4, 162000, 0, 0);
    check("R3 two lanes", lanes_out, 2);
    run_case("R3 four", 200000, 8, 4, 162000, 0, 0);
    check("R3 four lanes", lanes_out, 4);
    run_case("R3 capped", 200000, 8, 2, 162000, 0, 0);
    check("R3 capped lanes", lanes_out, 2);
    run_case("R3 above", 300000, 8, 4, 162000, 0, 0);
    check("R3 above rate", rate_out, 270000);
  endtask

  task automatic t_rates();
    run_case("R4 hi", 150000, 8, 1, 540000, 1, 0);
    check("R4 hi rate", rate_out, 540000);
    check("R4 hi ok", mode_bad, 0);
    run_case("R5 hi blocked", 150000, 8, 1, 540000, 0, 0);
    check("R7 flagged", mode_bad, 1);
    run_case("R5 none", 200000, 8, 1, 540000, 1, 0);
    check("R5 none rate", rate_out, 540000);
    run_case("R5 low sink", 150000, 8, 1, 270000, 0, 0);
    check("R5 low sink rate", rate_out, 270000);
  endtask

  task automatic t_bridge();
    run_case("R6 small", 10000, 8, 4, 540000, 1, 1);
    check("R6 small rate", rate_out, 270000);
    run_case("R6 wide", 300000, 8, 4, 540000, 1, 1);
    check("R6 wide lanes", lanes_out, 2);
    check("R6 wide rate", rate_out, 270000);
  endtask

  task automatic t_edge();
    run_case("R8 exact", 54000, 8, 4, 270000, 0, 0);
    check("R8 exact rate", rate_out, 162000);
    run_case("R8 over", 54001, 8, 4, 270000, 0, 0);
    check("R8 over rate", rate_out, 270000);
    run_case("R8 floor", 61714, 7, 4, 270000, 0, 0);
    check("R8 floor rate", rate_out, 162000);
    run_case("R8 floor over", 61715, 7, 4, 270000, 0, 0);
    check("R8 floor over rate", rate_out, 270000);
  endtask

  task automatic t_busy();
    launch(100000, 8, 4, 162000, 0, 0);
    check("R1 busy", busy, 1);
    @(negedge clk);
    launch(10000, 8, 1, 540000, 1, 1);
    wait_done("R1 ignore");
    check("R1 busy low at done", busy, 0);
    check("R1 first lanes", lanes_out, 2);
    check("R1 first rate", rate_out, 162000);
    @(negedge clk);
    check("R1 done one cycle", done, 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        miscompares++;
        vectors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_depth();
    t_lanes();
    t_rates();
    t_bridge();
    t_edge();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule